// File: doc/BRIEF.md
# Switched-Capacitor Sampler Readout Sequencer

This controller runs a circular analog sampling array of `CELLS` cells per channel that is digitised by an external converter. Out of reset it holds the chip's enable and write strobes low, so the sampling wave cannot start until software raises `run`. Once running, the array samples continuously until a trigger arrives. The trigger is the OR of an external digital input and an internal comparator output. On a trigger the block drops the write strobe and captures the stop cell that the chip reports.

The block then emits one readout strobe per clock. Each strobe carries the physical cell, the index relative to the first cell read, and the channel. The cells come either from the whole array or from a region of interest of programmable length that starts at the stop cell plus a signed offset. Channels in the enable mask are read one after another in ascending order. After the last sample the block restarts writing for one cycle. It then waits through an optional hold-off so the supply can settle, and only then accepts a new trigger. The length of every dead interval is reported, and triggers that arrive while the block cannot take them are counted.

Top module: `scarray_seq`

## Requirements
- R1: After reset, `samp_en`, `samp_wr`, `busy`, `rd_valid` and `dead_stb` are 0. While `run` is 0 the block stays idle, and a trigger starts no readout.
- R2: One clock after `run` is seen high in the idle state, `samp_en` and `samp_wr` are both 1, and the block is armed.
- R3: While armed with `run` high, a trigger accepted on `trig_ext` or on `trig_cmp` causes `samp_wr` to read 0 and `busy` to read 1 one clock later. `stop_cell` is captured on that same edge.
- R4: With `roi_en` = 0, each channel emits `CELLS` strobes. The first strobe is at the captured stop cell, and each later strobe is one cell higher, wrapping from `CELLS-1` to 0. `rd_idx` counts 0 to `CELLS-1`, and the first strobe comes two clocks after the trigger edge.
- R5: With `roi_en` = 1 and 1 <= `roi_len` <= `CELLS`, each channel emits `roi_len` strobes. They start at (stop cell + `roi_ofs`) modulo `CELLS`, where `roi_ofs` is two's complement.
- R6: Each channel whose bit is set in `ch_mask` is read in full, in ascending channel order, with no gap between channels. A mask of 0 reads channel 0 only.
- R7: After the last strobe, one restart cycle follows with `samp_wr` = 1 and `busy` = 1. It is followed by `holdoff` cycles that keep `busy` = 1, during which triggers are not accepted.
- R8: On the first cycle with `busy` back at 0, `dead_stb` is 1 for one cycle. At that point `dead_len` = 2 + (number of channels read) × (samples per channel) + `holdoff`.
- R9: `ign_cnt` increases by one for every clock in which a trigger is high and the block is not armed with `run` high. Such a trigger produces no strobes.
- R10: If `run` is 0 when the dead interval ends, the block returns to idle with `samp_en` = `samp_wr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one readout per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Level: permit sampling and re-arming |
| roi_en | input | 1 | 1 selects region-of-interest readout |
| roi_len | input | CW+1 | Samples per channel in region mode |
| roi_ofs | input | CW | Signed start offset from the stop cell |
| ch_mask | input | NCH | Channels to read |
| holdoff | input | HOLD_W | Settling cycles before re-arm |
| trig_ext | input | 1 | External digital trigger |
| trig_cmp | input | 1 | Internal comparator trigger |
| stop_cell_in | input | CW | Stop position reported by the chip |
| samp_en | output | 1 | Sampling wave enable |
| samp_wr | output | 1 | Array write strobe |
| busy | output | 1 | Dead interval in progress |
| rd_valid | output | 1 | Readout strobe |
| rd_cell | output | CW | Physical cell of this strobe |
| rd_idx | output | CW+1 | Index relative to the first cell read |
| rd_ch | output | CHW | Channel of this strobe |
| dead_stb | output | 1 | Pulse when a dead interval ends |
| dead_len | output | DEAD_W | Length of the last dead interval in cycles |
| ign_cnt | output | IGN_W | Count of ignored trigger cycles (wraps) |

## Verification
The assertions assume that the readout length latched for an event is at least one. They also assume that `stop_cell_in` is valid on the edge where a trigger is accepted, and that triggers are synchronous to `clk`. The bench changes inputs only on the falling edge, and it holds the configuration stable from the trigger until the readout starts. It uses region lengths between 1 and `CELLS`, and it presents the stop cell on the same cycle as the trigger. Triggers during the dead interval are one-cycle pulses, so the ignore count changes by a known amount.

// File: rtl/scarray_seq.sv
module scarray_seq #(
  parameter int CELLS  = 1024,
  parameter int NCH    = 4,
  parameter int HOLD_W = 12,
  parameter int DEAD_W = 20,
  parameter int IGN_W  = 8,
  localparam int CW    = $clog2(CELLS),
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              roi_en,
  input  logic [CW:0]       roi_len,
  input  logic [CW-1:0]     roi_ofs,
  input  logic [NCH-1:0]    ch_mask,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic              trig_ext,
  input  logic              trig_cmp,
  input  logic [CW-1:0]     stop_cell_in,
  output logic              samp_en,
  output logic              samp_wr,
  output logic              busy,
  output logic              rd_valid,
  output logic [CW-1:0]     rd_cell,
  output logic [CW:0]       rd_idx,
  output logic [CHW-1:0]    rd_ch,
  output logic              dead_stb,
  output logic [DEAD_W-1:0] dead_len,
  output logic [IGN_W-1:0]  ign_cnt
);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_STOP, S_READ, S_RESTART, S_HOLD} st_t;

  st_t               st;
  logic [CW-1:0]     stop_q, start_q;
  logic [CW:0]       len_q, idx;
  logic [CHW-1:0]    ch_q, first_ch, nxt_ch;
  logic [NCH-1:0]    mask_q, eff_mask;
  logic [HOLD_W-1:0] hold_q, hcnt;
  logic [DEAD_W-1:0] dead_cnt;
  logic              trig, nxt_ok, accept, end_dead;
  logic [CW:0]       sel_len;

  assign trig     = trig_ext | trig_cmp;
  assign accept   = (st == S_ARMED) && run && trig;
  assign eff_mask = (ch_mask == '0) ? NCH'(1) : ch_mask;
  assign sel_len  = (roi_en && roi_len != '0 && roi_len <= (CW+1)'(CELLS)) ? roi_len : (CW+1)'(CELLS);
  assign end_dead = ((st == S_RESTART) && (hold_q == '0)) || ((st == S_HOLD) && (hcnt == '0));

  always_comb begin
    first_ch = '0;
    nxt_ok   = 1'b0;
    nxt_ch   = ch_q;
    for (int i = NCH-1; i >= 0; i--) begin
      if (eff_mask[i]) first_ch = CHW'(i);
      if (mask_q[i] && i > int'(ch_q)) begin
        nxt_ok = 1'b1;
        nxt_ch = CHW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      stop_q  <= '0;
      start_q <= '0;
      len_q   <= '0;
      idx     <= '0;
      ch_q    <= '0;
      mask_q  <= '0;
      hold_q  <= '0;
      hcnt    <= '0;
    end else begin
      case (st)
        S_IDLE:  if (run) st <= S_ARMED;
        S_ARMED: begin
          if (!run) st <= S_IDLE;
          else if (trig) begin
            st     <= S_STOP;
            stop_q <= stop_cell_in;
          end
        end
        S_STOP: begin
          start_q <= roi_en ? stop_q + roi_ofs : stop_q;
          len_q   <= sel_len;
          mask_q  <= eff_mask;
          ch_q    <= first_ch;
          hold_q  <= holdoff;
          idx     <= '0;
          st      <= S_READ;
        end
        S_READ: begin
          if (idx == len_q - 1'b1) begin
            idx <= '0;
            if (nxt_ok) ch_q <= nxt_ch;
            else st <= S_RESTART;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RESTART: begin
          if (hold_q == '0) st <= run ? S_ARMED : S_IDLE;
          else begin
            hcnt <= hold_q - 1'b1;
            st   <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (hcnt == '0) st <= run ? S_ARMED : S_IDLE;
          else hcnt <= hcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_cnt <= '0;
      dead_len <= '0;
      dead_stb <= 1'b0;
      ign_cnt  <= '0;
    end else begin
      dead_cnt <= busy ? dead_cnt + 1'b1 : '0;
      dead_stb <= end_dead;
      if (end_dead) dead_len <= dead_cnt + 1'b1;
      if (trig && !((st == S_ARMED) && run)) ign_cnt <= ign_cnt + 1'b1;
    end
  end

  assign samp_en  = (st != S_IDLE);
  assign samp_wr  = (st == S_ARMED) || (st == S_RESTART) || (st == S_HOLD);
  assign busy     = (st == S_STOP) || (st == S_READ) || (st == S_RESTART) || (st == S_HOLD);
  assign rd_valid = (st == S_READ);
  assign rd_cell  = start_q + idx[CW-1:0];
  assign rd_idx   = idx;
  assign rd_ch    = ch_q;

  AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) samp_wr |-> samp_en); // R1
  AST_TRIG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) accept |=> (!samp_wr && busy)); // R3
  AST_NO_WR_READ:  assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !samp_wr); // R4
  AST_CELL_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                     (rd_valid && $past(rd_valid) && rd_idx != '0) |-> (rd_cell == $past(rd_cell) + CW'(1))); // R4
  AST_DEAD_END:    assert property (@(posedge clk) disable iff (!rst_n) dead_stb |-> (!busy && $past(busy))); // R8
  AST_IGN_COUNT:   assert property (@(posedge clk) disable iff (!rst_n)
                     (trig && !((st == S_ARMED) && run)) |=> (ign_cnt == $past(ign_cnt) + IGN_W'(1))); // R9

endmodule

// File: tb/sim_scarray_seq.sv
module sim_scarray_seq;
  localparam int CELLS = 1024, NCH = 4, HOLD_W = 12, DEAD_W = 20, IGN_W = 8;
  localparam int CW = 10, CHW = 2;

  logic clk = 0, rst_n = 0, run = 0, roi_en = 0, trig_ext = 0, trig_cmp = 0;
  logic [CW:0] roi_len = 0;
  logic [CW-1:0] roi_ofs = 0, stop_cell_in = 0;
  logic [NCH-1:0] ch_mask = 0;
  logic [HOLD_W-1:0] holdoff = 0;
  logic samp_en, samp_wr, busy, rd_valid, dead_stb;
  logic [CW-1:0] rd_cell;
  logic [CW:0] rd_idx;
  logic [CHW-1:0] rd_ch;
  logic [DEAD_W-1:0] dead_len;
  logic [IGN_W-1:0] ign_cnt;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scarray_seq #(.CELLS(CELLS), .NCH(NCH), .HOLD_W(HOLD_W), .DEAD_W(DEAD_W), .IGN_W(IGN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .roi_en(roi_en), .roi_len(roi_len), .roi_ofs(roi_ofs),
    .ch_mask(ch_mask), .holdoff(holdoff), .trig_ext(trig_ext), .trig_cmp(trig_cmp),
    .stop_cell_in(stop_cell_in), .samp_en(samp_en), .samp_wr(samp_wr), .busy(busy),
    .rd_valid(rd_valid), .rd_cell(rd_cell), .rd_idx(rd_idx), .rd_ch(rd_ch),
    .dead_stb(dead_stb), .dead_len(dead_len), .ign_cnt(ign_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    logic [IGN_W-1:0] ig;
    @(negedge clk);
    chk("R1 en", samp_en, 0); chk("R1 wr", samp_wr, 0); chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 dead_stb", dead_stb, 0);
    ig = ign_cnt;
    trig_ext = 1; @(negedge clk); trig_ext = 0;
    repeat (3) @(negedge clk);
    chk("R1 idle trig busy", busy, 0); chk("R1 idle en", samp_en, 0);
    chk("R9 idle trig counted", int'(ign_cnt), int'(ig) + 1);
  endtask

  task automatic t_arm;
    run = 1; @(negedge clk);
    chk("R2 en", samp_en, 1); chk("R2 wr", samp_wr, 1); chk("R2 busy", busy, 0);
  endtask

  task automatic do_event(input string tag, input bit use_cmp, input int stop, input bit roi,
                          input int len, input int ofs, input int mask, input int hold,
                          input bit drop_run);
    int chs[$];
    int n, start, errs, k, ci, ec, ig0;
    errs = 0;
    roi_en = roi; roi_len = (CW+1)'(len); roi_ofs = CW'(ofs); ch_mask = NCH'(mask);
    holdoff = HOLD_W'(hold); stop_cell_in = CW'(stop);
    for (int c = 0; c < NCH; c++) if (mask[c]) chs.push_back(c);
    if (chs.size() == 0) chs.push_back(0);
    n = roi ? len : CELLS;
    start = roi ? (((stop + ofs) % CELLS) + CELLS) % CELLS : stop;
    if (use_cmp) trig_cmp = 1; else trig_ext = 1;
    @(negedge clk);
    trig_cmp = 0; trig_ext = 0;
    chk({tag, " R3 wr low"}, samp_wr, 0); chk({tag, " R3 busy"}, busy, 1);
    @(negedge clk);
    for (k = 0; k < n * chs.size(); k++) begin
      ci = k / n;
      ec = (start + (k % n)) % CELLS;
      if (!rd_valid || rd_cell != CW'(ec) || int'(rd_ch) != chs[ci] || int'(rd_idx) != k % n) begin
        if (errs == 0)
          $display("FAIL %s R4/R5/R6 sample %0d actual v=%0d cell=%0d ch=%0d idx=%0d expected cell=%0d ch=%0d idx=%0d",
                   tag, k, rd_valid, rd_cell, rd_ch, rd_idx, ec, chs[ci], k % n);
        errs++;
      end
      @(negedge clk);
    end
    checks++; if (errs != 0) failures++;
    chk({tag, " R7 restart wr"}, samp_wr, 1); chk({tag, " R7 restart busy"}, busy, 1);
    chk({tag, " R7 restart no strobe"}, rd_valid, 0);
    @(negedge clk);
    ig0 = int'(ign_cnt);
    for (int i = 0; i < hold; i++) begin
      if (!busy || rd_valid) begin
        failures++; checks++;
        $display("FAIL %s R7 holdoff cycle %0d busy=%0d rd_valid=%0d expected 1/0", tag, i, busy, rd_valid);
      end
      if (drop_run && i == 0) run = 0;
      if (hold >= 3 && i == 1) trig_ext = 1;
      if (hold >= 3 && i == 2) begin
        trig_ext = 0;
        chk({tag, " R9 holdoff trig counted"}, int'(ign_cnt), (ig0 + 1) % 256);
      end
      @(negedge clk);
    end
    chk({tag, " R8 busy low"}, busy, 0); chk({tag, " R8 dead_stb"}, dead_stb, 1);
    chk({tag, " R8 dead_len"}, int'(dead_len), 2 + chs.size() * n + hold);
    chk({tag, " R7 no late readout"}, rd_valid, 0);
    if (drop_run) begin
      chk({tag, " R10 en low"}, samp_en, 0); chk({tag, " R10 wr low"}, samp_wr, 0);
    end else begin
      chk({tag, " R7 rearmed wr"}, samp_wr, 1);
    end
    @(negedge clk);
    chk({tag, " R8 stb one cycle"}, dead_stb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_arm;
    do_event("full_wrap", 0, 1000, 0, 0, 0, 1, 0, 0);     // R4
    do_event("roi_neg", 1, 5, 1, 20, -10, 1, 0, 0);       // R5
    do_event("roi_pos", 0, 1020, 1, 9, 2, 1, 4, 0);       // R5
    do_event("multi_ch", 1, 300, 1, 8, 0, 4'b1010, 0, 0); // R6
    do_event("mask0", 0, 77, 1, 3, 0, 0, 0, 0);           // R6
    do_event("roi_one", 0, 1023, 1, 1, 0, 4'b1111, 0, 0); // R5 R6
    do_event("holdoff", 0, 12, 1, 16, 1, 1, 50, 0);       // R7 R9
    do_event("disarm", 1, 500, 1, 4, 0, 4'b0011, 5, 1);   // R10
    t_arm;
    do_event("rearm_full", 1, 0, 0, 0, 0, 4'b0100, 3, 0); // R4 R2
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule